// File: doc/BRIEF.md
# Integer Execute Unit with Condition Code

This block is the integer execute stage of a 32-bit processor core. Each cycle it may accept one instruction word together with the two register operand values that the register file already read for it. It covers the add/subtract, shift and bitwise opcode groups. One clock later it presents a result, a destination register number and a write strobe for the register file. It also keeps a status word in which bit 2 is the condition code (CC) that later branches test.

The six-bit opcode sits in bits 31:26 and the destination register field in bits 20:16. The low 16 bits hold the immediate. An odd opcode uses that immediate as the first operand in place of the src1 register value. The second operand is always the src2 register value. Subtraction takes the first operand minus the second. The meaning of CC depends on the operation: carry, borrow, signed less-than or zero result. Shifts leave CC alone. Opcodes below 0x20 are not executed here and cause neither a write nor a CC change.

Top module: `intExecUnit`

## Requirements
- R1: An instruction is executed only when issueValid is high and opcode bit 5 (instruction bit 31) is set. Otherwise wrEn is low in the next cycle and the status word keeps its value.
- R2: Opcode 0x20/0x21 (unsigned add) writes the low 32 bits of operand1 + src2 and sets CC to the carry out of bit 31.
- R3: Opcode 0x24/0x25 (signed add) writes the same sum as unsigned add, and CC is again the unsigned carry out of bit 31.
- R4: Opcode 0x22/0x23 (unsigned subtract) writes operand1 − src2, not the reverse, and sets CC when operand1 < src2 compared as unsigned.
- R5: Opcode 0x26/0x27 (signed subtract) writes operand1 − src2 and sets CC when operand1 < src2 compared as two's-complement signed.
- R6: For the add and subtract groups, an odd opcode replaces src1 with the 16-bit immediate (instruction bits 15:0), sign-extended to 32 bits.
- R7: Shifts (0x28/0x29 left, 0x2A/0x2B logical right) use as their count bits 4:0 of the immediate (odd opcode) or of src1 (even opcode), shift the src2 value, and leave CC unchanged.
- R8: Opcode 0x2E/0x2F shifts right arithmetically, filling with the sign bit. Opcode 0x2C/0x2D shifts right logically, filling with zeros.
- R9: The bitwise groups compute src2 AND op1 (0x30–0x33), src2 AND NOT op1 (0x34–0x37), src2 OR op1 (0x38–0x3B) and src2 XOR op1 (0x3C–0x3F). CC is set exactly when the 32-bit result is zero.
- R10: In immediate form the bitwise groups zero-extend the immediate. The opcodes with bit 1 set (0x33, 0x37, 0x3B, 0x3F) place it in bits 31:16 with zeros below.
- R11: An executed instruction whose destination field is 0 raises no wrEn. Its CC update still takes place.
- R12: Results appear on wrEn, wrAddr and wrData in the cycle after issue. Reset clears wrEn, wrAddr, wrData and the whole status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| issueValid | input | 1 | Instruction word and operands valid this cycle |
| instr | input | 32 | Instruction word |
| src1Val | input | 32 | Value of the src1 register |
| src2Val | input | 32 | Value of the src2 register |
| wrEn | output | 1 | Register-file write strobe, one cycle after issue |
| wrAddr | output | 5 | Destination register number |
| wrData | output | 32 | Result value |
| statusWord | output | 32 | Status word; bit 2 is CC, all other bits zero |

## Verification
The assertions assume that issueValid, instr and the operand values are settled before each rising edge and are never unknown. They also assume the decode fields sit at the stated bit positions, so the checker can read the opcode and destination fields straight from instr. The stimulus meets these assumptions by driving every input on the falling edge from bench tasks, with fully defined values. It mixes directed edge operands (all-ones, sign boundary, zero results, counts above 31) with pseudo-random words. Those random words are weighted toward executable opcodes, but they also include low opcodes, idle cycles and destination 0.

// File: rtl/intExecPkg.sv
package intExecPkg;
  localparam int OPC_W    = 6;
  localparam int OPC_LSB  = 26;
  localparam int DEST_LSB = 16;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_SHL, OP_SHR, OP_SHRA,
    OP_AND, OP_ANDN, OP_OR, OP_XOR
  } aluOpE;

  typedef enum logic [2:0] {
    CC_KEEP, CC_CARRY, CC_BORROW, CC_SLT, CC_ZERO
  } ccSelE;

  typedef struct packed {
    logic  exec;
    logic  useImm;
    logic  immSext;
    logic  immHigh;
    aluOpE aluOp;
    ccSelE ccSel;
  } ctrlStrobeT;
endpackage

// File: rtl/intExecCtrl.sv
module intExecCtrl
  import intExecPkg::*;
(
  input  logic             issueValid,
  input  logic [OPC_W-1:0] opcode,
  output ctrlStrobeT       strobe
);
  always_comb begin
    strobe         = '0;
    strobe.exec    = issueValid & opcode[OPC_W-1];
    strobe.useImm  = opcode[0];
    strobe.immSext = ~opcode[4];
    strobe.immHigh = opcode[4] & opcode[1];
    strobe.aluOp   = OP_ADD;
    strobe.ccSel   = CC_KEEP;
    unique case (opcode[4:1])
      4'h0, 4'h2: begin strobe.aluOp = OP_ADD;  strobe.ccSel = CC_CARRY;  end
      4'h1:       begin strobe.aluOp = OP_SUB;  strobe.ccSel = CC_BORROW; end
      4'h3:       begin strobe.aluOp = OP_SUB;  strobe.ccSel = CC_SLT;    end
      4'h4:       strobe.aluOp = OP_SHL;
      4'h5, 4'h6: strobe.aluOp = OP_SHR;
      4'h7:       strobe.aluOp = OP_SHRA;
      4'h8, 4'h9: begin strobe.aluOp = OP_AND;  strobe.ccSel = CC_ZERO; end
      4'hA, 4'hB: begin strobe.aluOp = OP_ANDN; strobe.ccSel = CC_ZERO; end
      4'hC, 4'hD: begin strobe.aluOp = OP_OR;   strobe.ccSel = CC_ZERO; end
      default:    begin strobe.aluOp = OP_XOR;  strobe.ccSel = CC_ZERO; end
    endcase
  end
endmodule

// File: rtl/intExecDp.sv
module intExecDp
  import intExecPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int AW     = 5,
  parameter int CC_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [IMM_W-1:0]  imm,
  input  logic [AW-1:0]     destFld,
  input  logic [DATA_W-1:0] src1Val,
  input  logic [DATA_W-1:0] src2Val,
  output logic              wrEn,
  output logic [AW-1:0]     wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] statusWord
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] opA, opB, result, immExt;
  logic [DATA_W:0]   sumWide, diffWide;
  logic [CNT_W-1:0]  shCnt;
  logic              ccNext, ccReg;

  always_comb begin
    if (strobe.immSext)      immExt = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    else if (strobe.immHigh) immExt = {imm, {(DATA_W-IMM_W){1'b0}}};
    else                     immExt = {{(DATA_W-IMM_W){1'b0}}, imm};
  end

  assign opA      = strobe.useImm ? immExt : src1Val;
  assign opB      = src2Val;
  assign shCnt    = opA[CNT_W-1:0];
  assign sumWide  = {1'b0, opA} + {1'b0, opB};
  assign diffWide = {1'b0, opA} - {1'b0, opB};

  always_comb begin
    unique case (strobe.aluOp)
      OP_ADD:  result = sumWide[DATA_W-1:0];
      OP_SUB:  result = diffWide[DATA_W-1:0];
      OP_SHL:  result = opB << shCnt;
      OP_SHR:  result = opB >> shCnt;
      OP_SHRA: result = $unsigned($signed(opB) >>> shCnt);
      OP_AND:  result = opB & opA;
      OP_ANDN: result = opB & ~opA;
      OP_OR:   result = opB | opA;
      default: result = opB ^ opA;
    endcase
  end

  always_comb begin
    unique case (strobe.ccSel)
      CC_CARRY:  ccNext = sumWide[DATA_W];
      CC_BORROW: ccNext = diffWide[DATA_W];
      CC_SLT:    ccNext = $signed(opA) < $signed(opB);
      CC_ZERO:   ccNext = (result == '0);
      default:   ccNext = ccReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEn   <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
      ccReg  <= 1'b0;
    end else begin
      wrEn <= strobe.exec && (destFld != '0);
      if (strobe.exec) begin
        wrAddr <= destFld;
        wrData <= result;
        ccReg  <= ccNext;
      end
    end
  end

  for (genvar g = 0; g < DATA_W; g++) begin : gStatus
    if (g == CC_BIT) begin : gCc
      assign statusWord[g] = ccReg;
    end else begin : gZero
      assign statusWord[g] = 1'b0;
    end
  end
endmodule

// File: rtl/intExecUnit.sv
module intExecUnit
  import intExecPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int AW     = 5,
  parameter int CC_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] src1Val,
  input  logic [DATA_W-1:0] src2Val,
  output logic              wrEn,
  output logic [AW-1:0]     wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] statusWord
);
  ctrlStrobeT strobe;
  logic       unusedFields;

  assign unusedFields = ^instr[OPC_LSB-1:DEST_LSB+AW];

  intExecCtrl uCtrl (
    .issueValid (issueValid),
    .opcode     (instr[OPC_LSB +: OPC_W]),
    .strobe     (strobe)
  );

  intExecDp #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .AW     (AW),
    .CC_BIT (CC_BIT)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .imm        (instr[IMM_W-1:0]),
    .destFld    (instr[DEST_LSB +: AW]),
    .src1Val    (src1Val),
    .src2Val    (src2Val),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .statusWord (statusWord)
  );
endmodule

// File: rtl/intExecChk.sv
module intExecChk #(
  parameter int DATA_W = 32,
  parameter int AW     = 5,
  parameter int CC_BIT = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              issueValid,
  input logic [5:0]        opc,
  input logic [AW-1:0]     destFld,
  input logic              wrEn,
  input logic [AW-1:0]     wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] statusWord
);
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> !wrEn); // R1
  AST_LOW_OPC_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !opc[5] |=> !wrEn && $stable(statusWord)); // R1
  AST_SHIFT_KEEPS_CC: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && opc[5:3] == 3'b101 |=> $stable(statusWord[CC_BIT])); // R7
  AST_LOGIC_ZERO_CC: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && opc[5:4] == 2'b11 |=> statusWord[CC_BIT] == (wrData == '0)); // R9
  AST_DEST_ZERO_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && destFld == '0 |=> !wrEn); // R11
  AST_WRITE_ADDR_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> wrAddr != '0); // R11
  AST_ONE_CYCLE_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && opc[5] |=> wrAddr == $past(destFld)); // R12
endmodule

bind intExecUnit intExecChk #(.DATA_W(DATA_W), .AW(AW), .CC_BIT(CC_BIT)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .opc        (instr[31:26]),
  .destFld    (instr[20:16]),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .statusWord (statusWord)
);

// File: tb/sim_intExecUnit.sv
module sim_intExecUnit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] src1Val = '0;
  logic [31:0] src2Val = '0;
  logic        wrEn;
  logic [4:0]  wrAddr;
  logic [31:0] wrData;
  logic [31:0] statusWord;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  bit          expWrEn = 0;
  logic [4:0]  expAddr = '0;
  logic [31:0] expData = '0;
  bit          expCc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intExecUnit u0 (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .instr(instr),
    .src1Val(src1Val), .src2Val(src2Val), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .statusWord(statusWord)
  );

  function automatic logic [31:0] mk(int op, int dest, int imm);
    logic [31:0] w;
    w = '0;
    w[31:26] = op[5:0];
    w[20:16] = dest[4:0];
    w[15:0]  = imm[15:0];
    return w;
  endfunction

  task automatic checkVal(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference model: next-cycle expectations from the inputs now applied.
  task automatic model();
    int op, dest, cnt;
    longint unsigned a, b, wide;
    logic [31:0] res, imm32;
    bit cc;
    op = int'(instr[31:26]);
    dest = int'(instr[20:16]);
    if (!(issueValid && op >= 32)) begin
      expWrEn = 0;
      return;
    end
    b = longint'(src2Val);
    cc = expCc;
    res = '0;
    if (op < 40) begin
      imm32 = {{16{instr[15]}}, instr[15:0]};
      a = (op % 2 == 1) ? longint'(imm32) : longint'(src1Val);
      if (op == 32 || op == 33 || op == 36 || op == 37) begin
        wide = a + b;
        res = wide[31:0];
        cc = (wide >= 64'h1_0000_0000);
      end else begin
        res = 32'(a - b);
        if (op < 36) cc = (a < b);
        else cc = (int'(a[31:0]) < int'(b[31:0]));
      end
    end else if (op < 48) begin
      cnt = (op % 2 == 1) ? int'(instr[4:0]) : int'(src1Val[4:0]);
      if (op < 42) res = src2Val << cnt;
      else if (op < 46) res = src2Val >> cnt;
      else res = 32'(int'(src2Val) >>> cnt);
    end else begin
      if (op % 2 == 1) begin
        if ((op / 2) % 2 == 1) imm32 = {instr[15:0], 16'h0};
        else imm32 = {16'h0, instr[15:0]};
      end else imm32 = src1Val;
      if (op < 52) res = src2Val & imm32;
      else if (op < 56) res = src2Val & ~imm32;
      else if (op < 60) res = src2Val | imm32;
      else res = src2Val ^ imm32;
      cc = (res == 0);
    end
    expWrEn = (dest != 0);
    expAddr = 5'(dest);
    expData = res;
    expCc = cc;
  endtask

  task automatic compareAll(string tag);
    checkVal(tag, "wrEn", longint'(wrEn), longint'(expWrEn));
    if (expWrEn) begin
      checkVal(tag, "wrAddr", longint'(wrAddr), longint'(expAddr));
      checkVal(tag, "wrData", longint'(wrData), longint'(expData));
    end
    checkVal(tag, "statusWord", longint'(statusWord), expCc ? 64'd4 : 64'd0);
  endtask

  task automatic issue(string tag, bit v, logic [31:0] w, logic [31:0] a, logic [31:0] b);
    issueValid = v;
    instr = w;
    src1Val = a;
    src2Val = b;
    model();
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R12_reset");
    rstN = 1'b1;

    issue("R2_carry", 1, mk(32, 3, 0), 32'hFFFF_FFFF, 32'h1);
    issue("R2_nocarry", 1, mk(32, 4, 0), 32'd5, 32'd7);
    issue("R3_overflow_nocarry", 1, mk(36, 5, 0), 32'h1, 32'h7FFF_FFFF);
    issue("R3_carry", 1, mk(36, 5, 0), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    issue("R4_borrow", 1, mk(34, 6, 0), 32'd3, 32'd5);
    issue("R4_order", 1, mk(34, 6, 0), 32'd5, 32'd3);
    issue("R5_signed_lt", 1, mk(38, 7, 0), 32'hFFFF_FFFF, 32'd1);
    issue("R5_signed_ge", 1, mk(38, 7, 0), 32'd1, 32'hFFFF_FFFF);
    issue("R6_imm_sext_add", 1, mk(33, 8, 16'hFFFF), 32'hDEAD_BEEF, 32'd10);
    issue("R6_imm_sext_sub", 1, mk(35, 8, 16'h8000), 32'h0, 32'h0);
    issue("R7_setcc", 1, mk(48, 9, 0), 32'h0, 32'h5);
    issue("R7_shl_imm", 1, mk(41, 9, 16'h0023), 32'h0, 32'h0000_0011);
    issue("R7_shr_reg", 1, mk(42, 9, 0), 32'hFFFF_FFE4, 32'hF000_0000);
    issue("R8_shra", 1, mk(46, 10, 0), 32'd4, 32'h8000_0000);
    issue("R8_shrd", 1, mk(44, 10, 0), 32'd4, 32'h8000_0000);
    issue("R9_and_zero", 1, mk(48, 11, 0), 32'hF0F0_F0F0, 32'h0F0F_0F0F);
    issue("R9_or_nonzero", 1, mk(56, 11, 0), 32'h0, 32'h8000_0000);
    issue("R9_andnot", 1, mk(52, 11, 0), 32'hFFFF_0000, 32'h1234_5678);
    issue("R10_andh_imm", 1, mk(51, 12, 16'hFFFF), 32'h0, 32'h1234_5678);
    issue("R10_xor_zext", 1, mk(61, 12, 16'h8000), 32'h0, 32'h0);
    issue("R10_orh_imm", 1, mk(59, 12, 16'hABCD), 32'h0, 32'h0000_0001);
    issue("R11_dest0_setcc", 1, mk(32, 0, 0), 32'hFFFF_FFFF, 32'h2);
    issue("R11_dest0_zero", 1, mk(48, 0, 0), 32'h0, 32'hFFFF_FFFF);
    issue("R1_idle", 0, mk(32, 13, 0), 32'h1, 32'h1);
    issue("R1_low_opcode", 1, mk(4, 13, 0), 32'h1, 32'h1);
    issue("R12_after_idle", 1, mk(56, 14, 0), 32'h0, 32'h0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      w = $urandom;
      if (($urandom % 8) != 0) w[31] = 1'b1;
      if (($urandom % 10) == 0) w[20:16] = 5'd0;
      issue("RND_R1_R12", ($urandom % 6) != 0, w, $urandom, $urandom);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule